// File: doc/BRIEF.md
# Display RAM Address and Access Controller

This block sits between a host command/data interface and the display RAM of a dot-matrix panel controller. The RAM holds nine pages of one hundred byte-wide columns. The block interprets the host's address commands (page, column high and low nibbles, column mirroring, modify-read entry and exit) and turns host data strobes into RAM accesses at the addressed location.

Every data transfer passes through a one-byte bus holder. A write loads the host byte into the holder and commits it to RAM on the next cycle. A read hands the host the byte the holder already contains, then refills the holder from RAM at the current address. This is why the first read after a new address returns stale data. The column counter advances after each access and stops once it runs off the last column. Modify-read mode lets the host read a byte, change it and write it back in place, then return to the column where it started. Page 8 is a one-bit icon page, and pages above it map to no storage.

The access engine is a four-state machine. IDLE accepts strobes. An accepted data write goes IDLE→WR_COMMIT, and WR_COMMIT returns to IDLE after one cycle. An accepted read goes IDLE→RD_FETCH→RD_LOAD→IDLE. A command stays in IDLE.

Top module: `lcdram_access`

## Requirements
- R1: After reset the page, the column, modify-read mode and column mirroring are all zero or off, the bus holder and `host_dout` are 0x00, and the first write lands at page 0, column 0.
- R2: In IDLE, a command byte `1011_pppp` loads `pppp` into the page register and leaves the column unchanged.
- R3: In IDLE, a command byte `0001_0hhh` replaces column bits 6:4 with `hhh`, and a command byte `0000_llll` replaces column bits 3:0 with `llll`. Each leaves the other bits as they were.
- R4: A `data_wr` accepted in IDLE loads `host_din` into the holder. In the next cycle (WR_COMMIT) `ram_we` pulses once, with `ram_wdata` equal to the holder and the address captured at acceptance. An unlocked column then reads one higher.
- R5: A `data_rd` accepted in IDLE places the holder's current byte on `host_dout` from the next cycle on. RD_FETCH then pulses `ram_re` at the captured address, and RD_LOAD loads `ram_rdata` into the holder. As a result the first read after an address change returns stale data and the second returns the addressed byte.
- R6: The column increments only while it is at most 99. At 100 or above it stays put and accesses make no RAM strobe, and a read there refills the holder with 0x00. A column-set command releases the lock.
- R7: On page 8 a committed write carries only bit 0 (bits 7:1 are zero) and a refill keeps only bit 0. Pages 9 to 15 make no RAM strobe, a refill from them yields 0x00, and the column still advances.
- R8: Command `1110_0000` enters modify-read mode and saves the current column. In this mode reads leave the column unchanged and writes still increment it.
- R9: Command `1110_1110` leaves modify-read mode and restores the saved column. Outside the mode it has no effect.
- R10: Command `1010_000m` sets mirroring to `m`. While it is set, the RAM column address is 99 minus the column counter.
- R11: Strobes arriving outside IDLE are ignored. When strobes coincide in IDLE, the command strobe wins over a data write, and a data write wins over a read.
- R12: Any command byte not listed above changes neither the page, the column nor any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command byte strobe |
| data_wr | input | 1 | Display data write strobe |
| data_rd | input | 1 | Display data read request |
| host_din | input | 8 | Command or write byte from the host |
| host_dout | output | 8 | Read byte returned to the host |
| ram_page | output | 4 | RAM page address |
| ram_col | output | 7 | RAM column address (after mirroring) |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |

## Verification
A behavioural reference model runs beside the design and is compared with it on every clock. The stimulus covers several patterns:
- Sequential writes followed by back-to-back reads separate the stale first read from the addressed second one.
- Writes and reads across the column-99 boundary show whether the counter locks and whether a column set releases it.
- Modify-read sequences of read, read, write, write and exit tell a frozen column apart from an advancing one, and show the column being restored.
- Icon-page accesses, out-of-range pages, mirrored addressing, overlapping strobes and unknown command bytes each check that one rule holds while the rest of the state stays unchanged.

// File: rtl/lcdram_pkg.sv
package lcdram_pkg;

    localparam int BYTE_W   = 8;
    localparam int PAGE_W   = 4;
    localparam int COL_LO_W = 4;
    localparam int COL_HI_W = 3;
    localparam int COL_W    = COL_LO_W + COL_HI_W;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PAGE,
        CMD_COL_HI,
        CMD_COL_LO,
        CMD_MIRROR,
        CMD_RMW_ON,
        CMD_RMW_OFF
    } cmd_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_COMMIT,
        ST_RD_FETCH,
        ST_RD_LOAD
    } acc_state_t;

endpackage

// File: rtl/lcdram_cmd_decode.sv
module lcdram_cmd_decode
    import lcdram_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output cmd_kind_t         kind
);

    always_comb begin
        kind = CMD_NONE;
        unique casez (code)
            8'b1011_????: kind = CMD_PAGE;
            8'b0001_0???: kind = CMD_COL_HI;
            8'b0000_????: kind = CMD_COL_LO;
            8'b1010_000?: kind = CMD_MIRROR;
            8'b1110_0000: kind = CMD_RMW_ON;
            8'b1110_1110: kind = CMD_RMW_OFF;
            default:      kind = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/lcdram_page_reg.sv
module lcdram_page_reg
    import lcdram_pkg::*;
#(
    parameter int NUM_PAGES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_val,
    output logic [PAGE_W-1:0] page,
    output logic              page_ok,
    output logic              page_icon
);

    localparam logic [PAGE_W-1:0] ICON_PG = PAGE_W'(NUM_PAGES - 1);

    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (load) begin
            page_q <= load_val;
        end
    end

    assign page      = page_q;
    assign page_ok   = (page_q <= ICON_PG);
    assign page_icon = (page_q == ICON_PG);

    // R2
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (page == $past(load_val)));

    // R11
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page));

endmodule

// File: rtl/lcdram_col_ctr.sv
module lcdram_col_ctr
    import lcdram_pkg::*;
#(
    parameter int NUM_COLS = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_hi,
    input  logic [COL_HI_W-1:0] hi_val,
    input  logic                set_lo,
    input  logic [COL_LO_W-1:0] lo_val,
    input  logic                step,
    input  logic                save,
    input  logic                restore,
    output logic [COL_W-1:0]    col,
    output logic                col_ok
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] saved_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q   <= '0;
            saved_q <= '0;
        end else begin
            if (save) begin
                saved_q <= col_q;
            end
            if (restore) begin
                col_q <= saved_q;
            end else if (set_hi) begin
                col_q <= {hi_val, col_q[COL_LO_W-1:0]};
            end else if (set_lo) begin
                col_q <= {col_q[COL_W-1:COL_LO_W], lo_val};
            end else if (step && col_ok) begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    assign col    = col_q;
    assign col_ok = (col_q <= LAST_COL);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_ok && !set_hi && !set_lo && !restore) |=> $stable(col));

    // R4
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && col_ok && !set_hi && !set_lo && !restore)
            |=> (col == $past(col) + COL_W'(1)));

    // R3
    lo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_lo && !restore)
            |=> (col[COL_W-1:COL_LO_W] == $past(col[COL_W-1:COL_LO_W])));

endmodule

// File: rtl/lcdram_access.sv
module lcdram_access
    import lcdram_pkg::*;
#(
    parameter int NUM_PAGES = 9,
    parameter int NUM_COLS  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic [PAGE_W-1:0] ram_page,
    output logic [COL_W-1:0]  ram_col,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    input  logic [BYTE_W-1:0] ram_rdata
);

    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
    localparam logic [BYTE_W-1:0] ICON_MASK = BYTE_W'(1);
    localparam logic [PAGE_W-1:0] ICON_PG   = PAGE_W'(NUM_PAGES - 1);

    acc_state_t state_q, state_d;
    cmd_kind_t  dcd_kind;

    logic              take_cmd, take_wr, take_rd;
    logic              rmw_q, mirror_q;
    logic [PAGE_W-1:0] page_cur;
    logic              page_ok, page_icon;
    logic [COL_W-1:0]  col_cur, phys_col;
    logic              col_ok;
    logic [PAGE_W-1:0] acc_page_q;
    logic [COL_W-1:0]  acc_col_q;
    logic              acc_ok_q, acc_icon_q;
    logic [BYTE_W-1:0] holder_q, dout_q;
    logic              col_step;

    lcdram_cmd_decode u_dcd (
        .code (host_din),
        .kind (dcd_kind)
    );

    lcdram_page_reg #(.NUM_PAGES(NUM_PAGES)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_cmd && dcd_kind == CMD_PAGE),
        .load_val  (host_din[PAGE_W-1:0]),
        .page      (page_cur),
        .page_ok   (page_ok),
        .page_icon (page_icon)
    );

    lcdram_col_ctr #(.NUM_COLS(NUM_COLS)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hi  (take_cmd && dcd_kind == CMD_COL_HI),
        .hi_val  (host_din[COL_HI_W-1:0]),
        .set_lo  (take_cmd && dcd_kind == CMD_COL_LO),
        .lo_val  (host_din[COL_LO_W-1:0]),
        .step    (col_step),
        .save    (take_cmd && dcd_kind == CMD_RMW_ON),
        .restore (take_cmd && dcd_kind == CMD_RMW_OFF && rmw_q),
        .col     (col_cur),
        .col_ok  (col_ok)
    );

    // strobe acceptance and priority: command, then write, then read
    assign take_cmd = (state_q == ST_IDLE) && cmd_wr;
    assign take_wr  = (state_q == ST_IDLE) && !cmd_wr && data_wr;
    assign take_rd  = (state_q == ST_IDLE) && !cmd_wr && !data_wr && data_rd;
    assign col_step = take_wr || (take_rd && !rmw_q);
    assign phys_col = mirror_q ? (LAST_COL - col_cur) : col_cur;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and RAM strobes
    always_comb begin
        state_d   = state_q;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_page  = acc_page_q;
        ram_col   = acc_col_q;
        ram_wdata = acc_icon_q ? (holder_q & ICON_MASK) : holder_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_wr) begin
                    state_d = ST_WR_COMMIT;
                end else if (take_rd) begin
                    state_d = ST_RD_FETCH;
                end
            end
            ST_WR_COMMIT: begin
                ram_we  = acc_ok_q;
                state_d = ST_IDLE;
            end
            ST_RD_FETCH: begin
                ram_re  = acc_ok_q;
                state_d = ST_RD_LOAD;
            end
            ST_RD_LOAD: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // access capture, bus holder and host read register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_page_q <= '0;
            acc_col_q  <= '0;
            acc_ok_q   <= 1'b0;
            acc_icon_q <= 1'b0;
            holder_q   <= '0;
            dout_q     <= '0;
        end else begin
            if (take_wr || take_rd) begin
                acc_page_q <= page_cur;
                acc_col_q  <= phys_col;
                acc_ok_q   <= page_ok && col_ok;
                acc_icon_q <= page_icon;
            end
            if (take_wr) begin
                holder_q <= host_din;
            end
            if (take_rd) begin
                dout_q <= holder_q;
            end
            if (state_q == ST_RD_LOAD) begin
                if (!acc_ok_q) begin
                    holder_q <= '0;
                end else if (acc_icon_q) begin
                    holder_q <= ram_rdata & ICON_MASK;
                end else begin
                    holder_q <= ram_rdata;
                end
            end
        end
    end

    // mode flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rmw_q    <= 1'b0;
            mirror_q <= 1'b0;
        end else if (take_cmd) begin
            unique case (dcd_kind)
                CMD_RMW_ON:  rmw_q    <= 1'b1;
                CMD_RMW_OFF: rmw_q    <= 1'b0;
                CMD_MIRROR:  mirror_q <= host_din[0];
                default:     ;
            endcase
        end
    end

    assign host_dout = dout_q;

    // R11
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R7
    icon_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_page == ICON_PG) |-> (ram_wdata[BYTE_W-1:1] == '0));

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_page <= ICON_PG && ram_col <= LAST_COL));

    // R2
    page_keeps_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && dcd_kind == CMD_PAGE) |=> $stable(col_cur));

    // R8
    rmw_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rd && rmw_q) |=> $stable(col_cur));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(col_cur) && $stable(page_cur) && $stable(host_dout)));

    // R5
    fetch_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (state_q == ST_RD_LOAD));

endmodule

// File: tb/lcdram_access_tb.sv
module lcdram_access_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout, ram_wdata, ram_rdata;
    logic [3:0] ram_page;
    logic [6:0] ram_col;
    logic       ram_we, ram_re;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdram_access u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .data_rd(data_rd), .host_din(host_din), .host_dout(host_dout),
        .ram_page(ram_page), .ram_col(ram_col), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    // storage the design talks to
    logic [7:0] dmem [9][100];
    logic [7:0] ram_q = 8'h00;
    assign ram_rdata = ram_q;

    int we_cnt = 0, cap_pg = -1, cap_col = -1, cap_dat = -1;

    always @(posedge clk) begin
        if (ram_we) begin
            dmem[int'(ram_page)][int'(ram_col)] <= ram_wdata;
            we_cnt  = we_cnt + 1;
            cap_pg  = int'(ram_page);
            cap_col = int'(ram_col);
            cap_dat = int'(ram_wdata);
        end
        if (ram_re) ram_q <= dmem[int'(ram_page)][int'(ram_col)];
    end

    // behavioural reference model
    int mm [9][100];
    int m_st, m_pg, m_col, m_saved, m_rmw, m_mir, m_hold, m_rd;
    int m_apg, m_acol, m_ok;

    task automatic m_launch();
        m_apg  = m_pg;
        m_acol = m_mir ? 99 - m_col : m_col;
        m_ok   = (m_pg <= 8 && m_col <= 99) ? 1 : 0;
    endtask

    task automatic m_cmd(input int b);
        if ((b & 8'hF0) == 8'hB0)      m_pg = b & 15;
        else if ((b & 8'hF8) == 8'h10) m_col = (m_col & 15) | ((b & 7) << 4);
        else if ((b & 8'hF0) == 8'h00) m_col = (m_col & 8'h70) | (b & 15);
        else if ((b & 8'hFE) == 8'hA0) m_mir = b & 1;
        else if (b == 8'hE0) begin m_rmw = 1; m_saved = m_col; end
        else if (b == 8'hEE) begin if (m_rmw != 0) m_col = m_saved; m_rmw = 0; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pg = 0; m_col = 0; m_saved = 0; m_rmw = 0; m_mir = 0;
            m_hold = 0; m_rd = 0; m_apg = 0; m_acol = 0; m_ok = 0;
        end else begin
            case (m_st)
                0: begin
                    if (cmd_wr) m_cmd(int'(host_din));
                    else if (data_wr) begin
                        m_hold = int'(host_din);
                        m_launch();
                        if (m_col <= 99) m_col++;
                        m_st = 1;
                    end else if (data_rd) begin
                        m_rd = m_hold;
                        m_launch();
                        if (m_rmw == 0 && m_col <= 99) m_col++;
                        m_st = 2;
                    end
                end
                1: begin
                    if (m_ok != 0) mm[m_apg][m_acol] = (m_apg == 8) ? (m_hold & 1) : m_hold;
                    m_st = 0;
                end
                2: m_st = 3;
                default: begin
                    if (m_ok == 0) m_hold = 0;
                    else m_hold = (m_apg == 8) ? (mm[m_apg][m_acol] & 1) : mm[m_apg][m_acol];
                    m_st = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 host_dout", int'(host_dout), m_rd);
            chk("R4 ram_we", int'(ram_we), (m_st == 1 && m_ok != 0) ? 1 : 0);
            chk("R5 ram_re", int'(ram_re), (m_st == 2 && m_ok != 0) ? 1 : 0);
            if (m_st == 1 && m_ok != 0) begin
                chk("R4 ram_page", int'(ram_page), m_apg);
                chk("R10 ram_col", int'(ram_col), m_acol);
                chk("R7 ram_wdata", int'(ram_wdata), (m_apg == 8) ? (m_hold & 1) : m_hold);
            end
        end
    end

    task automatic strobe(input bit c, input bit w, input bit r, input logic [7:0] b);
        @(negedge clk);
        cmd_wr = c; data_wr = w; data_rd = r; host_din = b;
        @(negedge clk);
        cmd_wr = 0; data_wr = 0; data_rd = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b); strobe(1, 0, 0, b); endtask
    task automatic wr(input logic [7:0] b);  strobe(0, 1, 0, b); endtask
    task automatic rd();                     strobe(0, 0, 1, 8'h00); endtask

    task automatic wcap(input string tag, input int pg, input int col, input int dat);
        chk(tag, cap_pg, pg);
        chk(tag, cap_col, col);
        chk(tag, cap_dat, dat);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        for (int p = 0; p < 9; p++)
            for (int c = 0; c < 100; c++) begin dmem[p][c] = 8'h00; mm[p][c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dout", int'(host_dout), 0);
        chk("R1 we", int'(ram_we), 0);
        wr(8'hAB);
        wcap("R1 first write", 0, 0, 8'hAB);

        // R2 R3 R4 addressing and sequential writes
        cmd(8'hB2); cmd(8'h11); cmd(8'h05);
        wr(8'h5A);
        wcap("R4 write", 2, 21, 8'h5A);
        wr(8'h3C);
        wcap("R4 increment", 2, 22, 8'h3C);

        // R5 dummy read pipeline
        cmd(8'h05);
        rd(); chk("R5 stale", int'(host_dout), 8'h3C);
        rd(); chk("R5 addressed", int'(host_dout), 8'h5A);
        rd(); chk("R5 next", int'(host_dout), 8'h3C);

        // R6 lock past last column
        cmd(8'h16); cmd(8'h03);
        wr(8'h77);
        wcap("R6 last column", 2, 99, 8'h77);
        n = we_cnt;
        wr(8'h88);
        chk("R6 locked write", we_cnt, n);
        cmd(8'h03);
        rd(); chk("R6 stale", int'(host_dout), 8'h88);
        rd(); chk("R6 col99", int'(host_dout), 8'h77);
        rd(); chk("R6 locked read", int'(host_dout), 8'h00);
        cmd(8'h00);
        wr(8'h11);
        wcap("R6 unlock", 2, 96, 8'h11);

        // R7 icon page and pages beyond it
        cmd(8'hB8); cmd(8'h10); cmd(8'h00);
        wr(8'hFF);
        wcap("R7 icon write", 8, 0, 8'h01);
        cmd(8'h00);
        rd(); chk("R7 stale", int'(host_dout), 8'hFF);
        rd(); chk("R7 icon read", int'(host_dout), 8'h01);
        cmd(8'hB9);
        n = we_cnt;
        wr(8'h42);
        chk("R7 no page 9 write", we_cnt, n);
        rd(); chk("R7 stale", int'(host_dout), 8'h42);
        rd(); chk("R7 page 9 read", int'(host_dout), 8'h00);

        // R8 R9 modify-read
        cmd(8'hB3); cmd(8'h10); cmd(8'h0A);
        wr(8'hA1); wr(8'hB2);
        cmd(8'h0A);
        cmd(8'hE0);
        rd(); chk("R8 stale", int'(host_dout), 8'hB2);
        rd(); chk("R8 read", int'(host_dout), 8'hA1);
        rd(); chk("R8 no increment", int'(host_dout), 8'hA1);
        wr(8'hC3);
        wcap("R8 write in place", 3, 10, 8'hC3);
        wr(8'hD4);
        wcap("R8 write increments", 3, 11, 8'hD4);
        cmd(8'hEE);
        wr(8'hE5);
        wcap("R9 restore", 3, 10, 8'hE5);
        cmd(8'hEE);
        wr(8'h5E);
        wcap("R9 exit outside mode", 3, 11, 8'h5E);

        // R10 mirrored columns
        cmd(8'hA1); cmd(8'hB4); cmd(8'h10); cmd(8'h05);
        wr(8'h99);
        wcap("R10 mirrored", 4, 94, 8'h99);
        cmd(8'hA0);
        wr(8'h9A);
        wcap("R10 normal", 4, 6, 8'h9A);

        // R11 strobes while busy, then coinciding strobes
        cmd(8'hB5); cmd(8'h10); cmd(8'h00);
        n = we_cnt;
        @(negedge clk); data_wr = 1; host_din = 8'h10;
        @(negedge clk); host_din = 8'h20;
        @(negedge clk); data_wr = 0;
        repeat (3) @(negedge clk);
        chk("R11 busy ignored", we_cnt, n + 1);
        wcap("R11 first kept", 5, 0, 8'h10);
        wr(8'h30);
        wcap("R11 single increment", 5, 1, 8'h30);
        n = we_cnt;
        strobe(1, 1, 1, 8'hB6);
        chk("R11 command wins", we_cnt, n);
        wr(8'h66);
        wcap("R11 page from command", 6, 2, 8'h66);

        // R12 unknown commands
        cmd(8'h40); cmd(8'hFF); cmd(8'hE5); cmd(8'h20); cmd(8'hA2);
        wr(8'h77);
        wcap("R12 no effect", 6, 3, 8'h77);

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule